// File: doc/BRIEF.md
# Ramp Converter Up/Down Counter with Clamped Activation Output

This block is the digital half of a column ramp-compare converter. It turns two analog samples, one taken with the positive weights and one with the negative weights, into a single unsigned activation value. Each sample is measured by counting clock cycles while the comparator reports that the ramp is still below the column voltage. The first sample counts up from a signed preset, which carries the batch-norm shift. The second sample counts down from where the first one ended, so the counter ends up holding preset + positive − negative.

A sample window starts when `start_i` is sampled high while no window is open. `dir_i` selects the role of that window. A value of 0 means an up-count window, and the counter is first loaded with `preset_i`. A value of 1 means a down-count window, and the counter keeps its current value. Every window lasts exactly 2^ACT_W clock cycles. When a down-count window closes, the signed total is clamped below at zero and saturated at full scale. The result is then latched onto `act_o`, together with a one-cycle `done_o` pulse.

Top module: `ramp_relu_counter`

## Requirements
- R1: While `rst` is high and right after it, `act_o` is 0 and `done_o` is 0.
- R2: A window opened with `dir_i` = 0 loads the signed two's-complement `preset_i` into the counter. It then adds one for each window cycle in which `cmp_i` is still high, counted before the first low.
- R3: A window opened with `dir_i` = 1 subtracts one for each such cycle. When it closes, `act_o` takes the clamped total and `done_o` is high for exactly one cycle.
- R4: A negative total latches as 0 on `act_o`.
- R5: A total above 2^ACT_W − 1 latches as all ones on `act_o`.
- R6: If `cmp_i` never goes low during a window, that sample contributes exactly 2^ACT_W − 1 counts.
- R7: Once `cmp_i` has been low in a window, the counter does not move again in that window, even if `cmp_i` returns high.
- R8: A window covers 2^ACT_W clock edges after the edge that accepted the start. `done_o` is high in the cycle after the last of those edges, and not one cycle earlier.
- R9: A `start_i` pulse while a window is open has no effect on the counting, the preset or the direction of that window.
- R10: `act_o` holds its value between latches. A new window may be started in the same cycle in which `done_o` is high.
- R11: The extreme preset combined with full-scale counts does not wrap. Minimum preset with a full down count gives 0, and maximum preset with a full up count gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a sample window when no window is open |
| dir_i | input | 1 | Window role: 0 up-count with preset load, 1 down-count and latch |
| preset_i | input | PRE_W | Signed two's-complement preset (batch-norm shift) |
| cmp_i | input | 1 | Comparator: high while the ramp is below the input |
| act_o | output | ACT_W | Latched clamped activation |
| done_o | output | 1 | One-cycle pulse when `act_o` is updated |

## Verification
Two events can fall in the same cycle. The first is the close of a down window, which latches the result and raises `done_o`. The second is the acceptance of the next conversion's start with its preset load. The bench provokes this by driving `start_i` during the `done_o` cycle. It then checks that `act_o` keeps the old result through the whole next up window, and that the following result is correct. A second coincidence is the comparator trip against the full-scale cap in the final window cycle. Vectors whose comparator never trips must land exactly on the capped count.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    localparam int unsigned DEF_ACT_W = 8;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    // Window control bundle shared by the datapath stages.
    typedef struct packed {
        logic accept;   // start taken this cycle
        logic active;   // window open
        logic last;     // final window cycle
    } win_ctl_t;

    // Clamp a signed total into [0, 2^w - 1].
    function automatic int unsigned relu_sat(input int signed v, input int unsigned w);
        int unsigned top_val;
        top_val = (32'd1 << w) - 32'd1;
        if (v < 0) begin
            return 32'd0;
        end
        if (unsigned'(v) > top_val) begin
            return top_val;
        end
        return unsigned'(v);
    endfunction

endpackage

// File: rtl/rrc_window.sv
module rrc_window
    import rrc_pkg::*;
#(
    parameter int unsigned ACT_W = DEF_ACT_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    output win_ctl_t ctl_o
);
    localparam logic [ACT_W-1:0] POS_ONE = 1;

    logic             active_q;
    logic [ACT_W-1:0] pos_q;

    always_comb begin
        ctl_o.accept = start_i && !active_q;
        ctl_o.active = active_q;
        ctl_o.last   = active_q && (pos_q == '1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            pos_q    <= '0;
        end else if (ctl_o.accept) begin
            active_q <= 1'b1;
            pos_q    <= '0;
        end else if (active_q) begin
            if (pos_q == '1) begin
                active_q <= 1'b0;
            end else begin
                pos_q <= pos_q + POS_ONE;
            end
        end
    end

endmodule

// File: rtl/rrc_sample_gate.sv
module rrc_sample_gate
    import rrc_pkg::*;
#(
    parameter int unsigned ACT_W = DEF_ACT_W
) (
    input  logic     clk,
    input  logic     rst,
    input  win_ctl_t ctl_i,
    input  logic     cmp_i,
    output logic     count_en_o
);
    localparam logic [ACT_W-1:0] CNT_ONE = 1;

    logic             tripped_q;
    logic [ACT_W-1:0] samp_q;

    // Count only while the ramp is still below, before any trip, below cap.
    assign count_en_o = ctl_i.active && !tripped_q && cmp_i && (samp_q != '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            tripped_q <= 1'b0;
            samp_q    <= '0;
        end else if (ctl_i.accept) begin
            tripped_q <= 1'b0;
            samp_q    <= '0;
        end else if (ctl_i.active) begin
            if (!cmp_i) begin
                tripped_q <= 1'b1;
            end
            if (count_en_o) begin
                samp_q <= samp_q + CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/rrc_accum.sv
module rrc_accum
    import rrc_pkg::*;
#(
    parameter int unsigned ACT_W = DEF_ACT_W,
    parameter int unsigned PRE_W = ACT_W + 2,
    parameter int unsigned ACC_W = ACT_W + 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  win_ctl_t                ctl_i,
    input  cnt_dir_e                dir_i,
    input  logic signed [PRE_W-1:0] preset_i,
    input  logic                    count_en_i,
    output cnt_dir_e                dir_q_o,
    output logic signed [ACC_W-1:0] acc_q_o,
    output logic signed [ACC_W-1:0] acc_next_o
);
    localparam logic signed [ACC_W-1:0] ACC_ONE = 1;

    cnt_dir_e                dir_q;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] preset_ext;

    assign preset_ext = {{(ACC_W-PRE_W){preset_i[PRE_W-1]}}, preset_i};

    always_comb begin
        acc_next_o = acc_q;
        if (count_en_i) begin
            acc_next_o = (dir_q == DIR_UP) ? acc_q + ACC_ONE : acc_q - ACC_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_UP;
            acc_q <= '0;
        end else if (ctl_i.accept) begin
            dir_q <= dir_i;
            if (dir_i == DIR_UP) begin
                acc_q <= preset_ext;
            end
        end else begin
            acc_q <= acc_next_o;
        end
    end

    assign dir_q_o = dir_q;
    assign acc_q_o = acc_q;

endmodule

// File: rtl/rrc_relu_latch.sv
module rrc_relu_latch
    import rrc_pkg::*;
#(
    parameter int unsigned ACT_W = DEF_ACT_W,
    parameter int unsigned ACC_W = ACT_W + 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  win_ctl_t                ctl_i,
    input  cnt_dir_e                dir_q_i,
    input  logic signed [ACC_W-1:0] acc_next_i,
    output logic [ACT_W-1:0]        act_o,
    output logic                    done_o
);
    logic fire;

    assign fire = ctl_i.last && (dir_q_i == DIR_DOWN);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= fire;
            if (fire) begin
                act_o <= ACT_W'(relu_sat(int'(acc_next_i), ACT_W));
            end
        end
    end

endmodule

// File: rtl/ramp_relu_counter.sv
module ramp_relu_counter
    import rrc_pkg::*;
#(
    parameter int unsigned ACT_W = DEF_ACT_W,
    parameter int unsigned PRE_W = ACT_W + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    dir_i,
    input  logic signed [PRE_W-1:0] preset_i,
    input  logic                    cmp_i,
    output logic [ACT_W-1:0]        act_o,
    output logic                    done_o
);
    localparam int unsigned ACC_W = PRE_W + 1;

    win_ctl_t                win_ctl;
    logic                    win_active;
    logic                    count_en;
    cnt_dir_e                dir_q;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_next;

    assign win_active = win_ctl.active;

    rrc_window #(.ACT_W(ACT_W)) u_window (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ctl_o   (win_ctl)
    );

    rrc_sample_gate #(.ACT_W(ACT_W)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (win_ctl),
        .cmp_i      (cmp_i),
        .count_en_o (count_en)
    );

    rrc_accum #(.ACT_W(ACT_W), .PRE_W(PRE_W), .ACC_W(ACC_W)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (win_ctl),
        .dir_i      (cnt_dir_e'(dir_i)),
        .preset_i   (preset_i),
        .count_en_i (count_en),
        .dir_q_o    (dir_q),
        .acc_q_o    (acc_q),
        .acc_next_o (acc_next)
    );

    rrc_relu_latch #(.ACT_W(ACT_W), .ACC_W(ACC_W)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (win_ctl),
        .dir_q_i    (dir_q),
        .acc_next_i (acc_next),
        .act_o      (act_o),
        .done_o     (done_o)
    );

endmodule

// File: rtl/rrc_checker.sv
module rrc_checker #(
    parameter int unsigned ACT_W = 8,
    parameter int unsigned ACC_W = ACT_W + 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start_i,
    input logic [ACT_W-1:0]        act_o,
    input logic                    done_o,
    input logic                    active,
    input logic signed [ACC_W-1:0] acc_q
);
    localparam logic signed [ACC_W-1:0] STEP = 1;

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                            // R3

    AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !active);                                            // R8

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (armed && !done_o) |-> $stable(act_o));                         // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(active)) |-> ((acc_q == $past(acc_q)) ||
                                      (acc_q == $past(acc_q) + STEP) ||
                                      (acc_q == $past(acc_q) - STEP))); // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (armed && !active && !start_i) |=> $stable(acc_q));             // R2

endmodule

bind ramp_relu_counter rrc_checker #(.ACT_W(ACT_W), .ACC_W(ACC_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .act_o   (act_o),
    .done_o  (done_o),
    .active  (win_active),
    .acc_q   (acc_q)
);

// File: tb/ramp_relu_counter_tb.sv
module ramp_relu_counter_tb;
    localparam int ACT_W = 8;
    localparam int PRE_W = ACT_W + 2;
    localparam int WIN   = 1 << ACT_W;
    localparam int FS    = WIN - 1;
    localparam int NV    = 10;
    localparam int NEVER = 999;   // comparator never trips

    // preset, up threshold, down threshold, requirement tag number
    localparam int T_PRE[NV] = '{0,   20,  0,  -10, 200, -10,   -512, 511,   5, 100};
    localparam int T_UP [NV] = '{100, 50,  30, 0,   200, NEVER, 0,    NEVER, 0, NEVER};
    localparam int T_DN [NV] = '{30,  10,  100,0,   10,  0,     NEVER,0,     0, NEVER};
    localparam int T_REQ[NV] = '{2,   3,   4,  4,   5,   6,     11,   11,    2, 6};
    // tags: R2 R3 R4 R4 R5 R6 R11 R11 R2 R6

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    start_i;
    logic                    dir_i;
    logic signed [PRE_W-1:0] preset_i;
    logic                    cmp_i;
    logic [ACT_W-1:0]        act_o;
    logic                    done_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4ns clk = ~clk;

    ramp_relu_counter #(.ACT_W(ACT_W), .PRE_W(PRE_W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .dir_i    (dir_i),
        .preset_i (preset_i),
        .cmp_i    (cmp_i),
        .act_o    (act_o),
        .done_o   (done_o)
    );

    function automatic int expect_act(input int pre, input int up, input int dn);
        int u, d, v;
        u = (up > FS) ? FS : up;
        d = (dn > FS) ? FS : dn;
        v = pre + u - d;
        if (v < 0)  return 0;
        if (v > FS) return FS;
        return v;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the last window edge.
    task automatic run_window(input bit down, input int pre, input int thr,
                              input int rebound_at, input int inject_at);
        start_i  = 1'b1;
        dir_i    = down;
        preset_i = PRE_W'(pre);
        @(posedge clk);
        @(negedge clk);
        start_i  = 1'b0;
        preset_i = '0;
        for (int k = 0; k < WIN; k++) begin
            cmp_i   = (k < thr) || (rebound_at >= 0 && k >= rebound_at);
            start_i = (k == inject_at);
            if (k == inject_at) begin
                dir_i    = ~down;
                preset_i = PRE_W'(77);
            end
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            if (down && k == WIN - 2) chk("R8 early done", int'(done_o), 0);
        end
        cmp_i = 1'b0;
    endtask

    task automatic conversion(input int pre, input int up, input int dn, input string req);
        run_window(1'b0, pre, up, -1, -1);
        run_window(1'b1, 0, dn, -1, -1);
        chk("R3 done", int'(done_o), 1);
        chk(req, int'(act_o), expect_act(pre, up, dn));
    endtask

    task automatic idle_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; dir_i = 1'b0; preset_i = '0; cmp_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 act", int'(act_o), 0);
        chk("R1 done", int'(done_o), 0);
        rst = 1'b0;
        idle_cycle();
        chk("R1 act after release", int'(act_o), 0);

        for (int i = 0; i < NV; i++) begin
            conversion(T_PRE[i], T_UP[i], T_DN[i], $sformatf("R%0d vec %0d", T_REQ[i], i));
            idle_cycle();
            chk("R3 done single", int'(done_o), 0);
        end

        // R7: comparator bounces high again after the trip
        run_window(1'b0, 0, 40, 100, -1);
        run_window(1'b1, 0, 0, 120, -1);
        chk("R7 sticky trip", int'(act_o), 40);
        idle_cycle();

        // R9: start pulses inside open windows are ignored
        run_window(1'b0, 10, 60, -1, 30);
        run_window(1'b1, 0, 20, -1, 100);
        chk("R9 start ignored", int'(act_o), 50);
        chk("R9 done", int'(done_o), 1);
        idle_cycle();

        // R10: new start in the done cycle, act held through next window
        conversion(0, 80, 0, "R10 first");
        run_window(1'b0, 0, 5, -1, -1);
        chk("R10 act held", int'(act_o), 80);
        chk("R10 no done", int'(done_o), 0);
        run_window(1'b1, 0, 0, -1, -1);
        chk("R10 second result", int'(act_o), 5);
        idle_cycle();

        // R4 and R5 boundary just inside range
        conversion(-1, 1, 0, "R4 zero edge");
        idle_cycle();
        conversion(0, FS, 0, "R5 full scale exact");
        idle_cycle();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule